// File: doc/BRIEF.md
# Down-Counting Timer with Repetition Gate

This block is a general-purpose timer core built around a down counter. A prescaler divides the input clock by a programmable ratio. Each divided tick lowers the count by one. When the count passes zero it wraps back to the active period value, and that wrap is an underflow. A repetition counter gates the underflows, so only one underflow in every N+1 raises an update event. The period, prescale ratio and repetition count each have a preload copy, which is written through a simple register port, and an active copy, which the logic uses.

An update event moves the preload copies into the active copies. It also reloads the counter and rearms the repetition counter. An update event has one of two causes: the repetition counter running out, or a software trigger strobe. A control register holds three bits. One blocks update events. One keeps software-triggered updates from setting the update flag. One chooses whether a period write is buffered until the next update or takes effect at once.

A two-state controller runs the counter. In `ST_HALT` the counter and prescaler hold their values. In `ST_RUN` they advance. The controller takes transition *start* (`ST_HALT` to `ST_RUN`) when it samples `cnt_en` high, and transition *stop* (`ST_RUN` to `ST_HALT`) when it samples `cnt_en` low. Because the state is registered, a change on `cnt_en` takes effect one clock after it is sampled.

Top module: `dntimer_core`

## Requirements
- R1: After reset `count`, `upd_pulse` and `upd_flag` are 0, and every preload, active and control register is 0.
- R2: On each prescaler tick the count drops by one. On the tick after it reaches 0, the count takes the active period value; this is an underflow.
- R3: In `ST_RUN` a tick occurs once every (prescale+1) clocks. In `ST_HALT` the count holds. The state follows `cnt_en` with one clock of delay.
- R4: With repetition value N, period A and prescale P held constant, update events fall exactly (P+1)(A+1)(N+1) clocks apart.
- R5: A one-cycle `upd_trig` forces an update event. In the following cycle the count equals the preload period, even when the controller is halted. The same event clears the prescaler and rearms the repetition counter.
- R6: While the hold bit (control bit 0) is 1, neither cause produces an update event, and the active prescale value keeps its old value. On each underflow the counter still reloads from the active period.
- R7: While the quiet bit (control bit 1) is 1, a triggered update pulses `upd_pulse` but leaves `upd_flag` alone. An update caused by the repetition counter always sets `upd_flag`.
- R8: While the buffer bit (control bit 2) is 1, a period write changes only the preload copy. The underflows before the next update event keep reloading the old period.
- R9: While the buffer bit is 0, a period write also changes the active copy at once, so the very next underflow reloads the new value.
- R10: `upd_pulse` is high for exactly the one cycle that follows each update event. `upd_flag` stays 1 until `flag_clr`. If a set and a clear fall in the same cycle, the set wins.
- R11: The write address selects the target register: 0 is the period, 1 the prescale value, 2 the repetition count and 3 the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 period, 1 prescale, 2 repetition, 3 control |
| wr_data | input | DW | Write data; control uses bits 2:0 (buffer, quiet, hold) |
| cnt_en | input | 1 | Counter enable, sampled into the run state |
| upd_trig | input | 1 | Software update trigger strobe |
| flag_clr | input | 1 | Clears the update flag |
| count | output | CW | Current counter value |
| upd_pulse | output | 1 | One-cycle update event pulse |
| upd_flag | output | 1 | Sticky update flag |

## Verification
The bench measures the spacing between update pulses for several settings of period, prescale and repetition. A design that reloaded the repetition counter at the wrong point, or that counted off by one somewhere in the chain, would give the wrong spacing. It writes a new period just after an update, with buffering on and then off. A design that copied the preload too early would make the first gap 6 instead of 8 when buffering is on. A design that ignored a direct write would make it 8 instead of 6 when buffering is off. With the hold bit set, the bench fires a trigger and stages a new prescale value, then checks that no pulse appears and that the count keeps its old step rate. It also checks that a quiet trigger never sets the flag, while a repetition update does.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_PRESC  = 2'd1;
    localparam logic [1:0] ADDR_REPEAT = 2'd2;
    localparam logic [1:0] ADDR_CTRL   = 2'd3;

    // bit 2: buffer period writes, bit 1: quiet software updates, bit 0: hold updates
    typedef struct packed {
        logic buf_period;
        logic quiet_sw;
        logic hold_upd;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dntimer_regs.sv
module dntimer_regs
    import dntimer_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int PW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          uev,
    output logic [CW-1:0] arr_pre,
    output logic [CW-1:0] arr_act,
    output logic [PW-1:0] psc_pre,
    output logic [PW-1:0] psc_act,
    output logic [RW-1:0] rep_pre,
    output ctrl_t         ctrl
);

    // Active copies follow the preload copies only on an update event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_act <= '0;
            psc_act <= '0;
        end else begin
            if (uev) begin
                arr_act <= arr_pre;
                psc_act <= psc_pre;
            end
            // An unbuffered period write overrides the update copy.
            if (wr_en && wr_addr == ADDR_PERIOD && !ctrl.buf_period) begin
                arr_act <= wr_data[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_pre <= '0;
            psc_pre <= '0;
            rep_pre <= '0;
            ctrl    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD: arr_pre <= wr_data[CW-1:0];
                ADDR_PRESC:  psc_pre <= wr_data[PW-1:0];
                ADDR_REPEAT: rep_pre <= wr_data[RW-1:0];
                ADDR_CTRL:   ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
            endcase
        end
    end

endmodule

// File: rtl/dntimer_presc.sv
module dntimer_presc #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] psc_act,
    output logic          tick
);

    logic [PW-1:0] pcnt;

    assign tick = run && (pcnt == psc_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr || tick) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/dntimer_cnt.sv
module dntimer_cnt
    import dntimer_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          tick,
    input  logic          trig,
    input  logic          hold,
    input  logic          quiet,
    input  logic          flag_clr,
    input  logic [CW-1:0] arr_act,
    input  logic [CW-1:0] arr_pre,
    input  logic [RW-1:0] rep_pre,
    output run_state_t    state,
    output logic [CW-1:0] count,
    output logic          rep_evt,
    output logic          sw_evt,
    output logic          uev,
    output logic          upd_pulse,
    output logic          upd_flag
);

    run_state_t    state_nxt;
    logic [RW-1:0] rep_cnt;
    logic          underflow;
    logic          flag_set;

    assign underflow = tick && (count == '0);
    assign rep_evt   = underflow && (rep_cnt == '0);
    assign sw_evt    = trig && !hold;
    assign uev       = (rep_evt && !hold) || sw_evt;
    assign flag_set  = (rep_evt && !hold) || (sw_evt && !quiet);

    // Transitions: start (HALT->RUN) and stop (RUN->HALT).
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HALT: if (cnt_en)  state_nxt = ST_RUN;
            ST_RUN:  if (!cnt_en) state_nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nxt;
    end

    // Counter and repetition counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            rep_cnt <= '0;
        end else if (uev) begin
            count   <= arr_pre;
            rep_cnt <= rep_pre;
        end else if (underflow) begin
            count <= arr_act;
            if (rep_cnt != '0) rep_cnt <= rep_cnt - 1'b1;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end

    // Event outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_flag  <= 1'b0;
        end else begin
            upd_pulse <= uev;
            if (flag_set)      upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dntimer_core.sv
module dntimer_core
    import dntimer_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int PW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          cnt_en,
    input  logic          upd_trig,
    input  logic          flag_clr,
    output logic [CW-1:0] count,
    output logic          upd_pulse,
    output logic          upd_flag
);

    logic [CW-1:0] arr_pre;
    logic [CW-1:0] arr_act;
    logic [PW-1:0] psc_pre;
    logic [PW-1:0] psc_act;
    logic [RW-1:0] rep_pre;
    ctrl_t         ctrl;
    run_state_t    run_st;
    logic          tick;
    logic          uev;
    logic          rep_evt;
    logic          sw_evt;
    logic          hold_w;
    logic          quiet_w;

    assign hold_w  = ctrl.hold_upd;
    assign quiet_w = ctrl.quiet_sw;

    dntimer_regs #(.DW(DW), .CW(CW), .PW(PW), .RW(RW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .uev     (uev),
        .arr_pre (arr_pre),
        .arr_act (arr_act),
        .psc_pre (psc_pre),
        .psc_act (psc_act),
        .rep_pre (rep_pre),
        .ctrl    (ctrl)
    );

    dntimer_presc #(.PW(PW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_st == ST_RUN),
        .clr     (sw_evt),
        .psc_act (psc_act),
        .tick    (tick)
    );

    dntimer_cnt #(.CW(CW), .RW(RW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .tick      (tick),
        .trig      (upd_trig),
        .hold      (hold_w),
        .quiet     (quiet_w),
        .flag_clr  (flag_clr),
        .arr_act   (arr_act),
        .arr_pre   (arr_pre),
        .rep_pre   (rep_pre),
        .state     (run_st),
        .count     (count),
        .rep_evt   (rep_evt),
        .sw_evt    (sw_evt),
        .uev       (uev),
        .upd_pulse (upd_pulse),
        .upd_flag  (upd_flag)
    );

endmodule

// File: rtl/dntimer_chk.sv
module dntimer_chk
    import dntimer_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic          upd_trig,
    input logic          flag_clr,
    input run_state_t    st,
    input logic          hold,
    input logic          quiet,
    input logic          uev,
    input logic          rep_evt,
    input logic [CW-1:0] arr_pre,
    input logic [CW-1:0] arr_act,
    input logic [CW-1:0] count,
    input logic          upd_pulse,
    input logic          upd_flag
);

    assert_halt_freezes_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !uev) |=> $stable(count));

    assert_repeat_event_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_evt && !hold) |=> (upd_pulse && upd_flag));

    assert_hold_blocks_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !upd_pulse);

    assert_quiet_trigger_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_trig && quiet && !hold && !rep_evt && !upd_flag) |=> !upd_flag);

    assert_shadow_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !$past(wr_en && wr_addr == ADDR_PERIOD)) |-> (arr_act == $past(arr_pre)));

    assert_flag_rises_with_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_flag) |-> upd_pulse);

    assert_clear_drops_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !uev) |=> !upd_flag);

endmodule

bind dntimer_core dntimer_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .upd_trig  (upd_trig),
    .flag_clr  (flag_clr),
    .st        (run_st),
    .hold      (hold_w),
    .quiet     (quiet_w),
    .uev       (uev),
    .rep_evt   (rep_evt),
    .arr_pre   (arr_pre),
    .arr_act   (arr_act),
    .count     (count),
    .upd_pulse (upd_pulse),
    .upd_flag  (upd_flag)
);

// File: tb/dntimer_core_tb.sv
module dntimer_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int LIMIT = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          cnt_en = 1'b0;
    logic          upd_trig = 1'b0;
    logic          flag_clr = 1'b0;
    logic [CW-1:0] count;
    logic          upd_pulse;
    logic          upd_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dntimer_core #(.DW(DW), .CW(CW), .PW(16), .RW(16)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_en    (cnt_en),
        .upd_trig  (upd_trig),
        .flag_clr  (flag_clr),
        .count     (count),
        .upd_pulse (upd_pulse),
        .upd_flag  (upd_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Caller stands at a negedge; returns one negedge later.
    task automatic wr(input logic [1:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic trig();
        upd_trig = 1'b1;
        @(negedge clk);
        upd_trig = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // Negedges from now until upd_pulse is seen high.
    task automatic wait_pulse(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!upd_pulse && g < LIMIT);
        if (g >= LIMIT) g = -1;
    endtask

    task automatic setup(input int p, input int a, input int n, input int c, input bit en);
        cnt_en = 1'b0;
        tick_n(3);
        wr(2'd3, c);
        wr(2'd1, p);
        wr(2'd2, n);
        wr(2'd0, a);
        trig();
        cnt_en = en;
    endtask

    task automatic t_reset();
        check(count == 0, "R1 count", int'(count), 0);
        check(!upd_pulse && !upd_flag, "R1 pulse/flag", int'({upd_pulse, upd_flag}), 0);
    endtask

    task automatic t_sequence();
        int prev;
        int exp;
        setup(0, 2, 0, 0, 1'b1);
        tick_n(4);
        prev = int'(count);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            exp = (prev == 0) ? 2 : prev - 1;
            check(int'(count) == exp, "R2 down count and reload", int'(count), exp);
            prev = int'(count);
        end
    endtask

    task automatic t_prescale_halt();
        int c0;
        int g;
        setup(2, 200, 0, 0, 1'b1);
        tick_n(3);
        c0 = int'(count);
        g = 0;
        while (int'(count) == c0 && g < LIMIT) begin @(negedge clk); g++; end
        c0 = int'(count);
        g = 0;
        while (int'(count) == c0 && g < LIMIT) begin @(negedge clk); g++; end
        check(g == 3, "R3 prescaler step", g, 3);
        cnt_en = 1'b0;
        tick_n(3);
        c0 = int'(count);
        tick_n(10);
        check(int'(count) == c0, "R3 halt holds count", int'(count), c0);
    endtask

    task automatic t_gap(input int p, input int a, input int n);
        int g;
        int exp;
        exp = (p + 1) * (a + 1) * (n + 1);
        setup(p, a, n, 0, 1'b1);
        wait_pulse(g);
        wait_pulse(g);
        check(g == exp, "R4 update spacing", g, exp);
    endtask

    task automatic t_trigger();
        setup(0, 3, 0, 4, 1'b0);
        tick_n(3);
        clear_flag();
        wr(2'd0, 9);
        tick_n(2);
        check(int'(count) == 3, "R8 buffered write keeps count while halted", int'(count), 3);
        trig();
        check(int'(count) == 9, "R5 trigger reloads preload period", int'(count), 9);
        check(upd_pulse == 1'b1, "R5 trigger pulses", int'(upd_pulse), 1);
        @(negedge clk);
        check(upd_pulse == 1'b0, "R10 pulse is one cycle", int'(upd_pulse), 0);
        tick_n(20);
        check(upd_flag == 1'b1, "R10 flag sticky", int'(upd_flag), 1);
        clear_flag();
        check(upd_flag == 1'b0, "R10 flag cleared", int'(upd_flag), 0);
    endtask

    task automatic t_hold();
        bit seen;
        bit steady;
        int mx;
        int mn;
        int prev;
        int g;
        setup(0, 5, 0, 0, 1'b1);
        tick_n(4);
        wr(2'd3, 1);
        clear_flag();
        wr(2'd1, 3);
        trig();
        seen = 1'b0; steady = 1'b1; mx = 0; mn = 99;
        prev = int'(count);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (upd_pulse) seen = 1'b1;
            if (int'(count) == prev) steady = 1'b0;
            if (int'(count) > mx) mx = int'(count);
            if (int'(count) < mn) mn = int'(count);
            prev = int'(count);
        end
        check(!seen, "R6 no update while held", int'(seen), 0);
        check(upd_flag == 1'b0, "R6 flag untouched while held", int'(upd_flag), 0);
        check(steady, "R6 prescale shadow unchanged (R11 map)", int'(steady), 1);
        check(mx == 5 && mn == 0, "R6 counter still reloads active period", mx, 5);
        wr(2'd3, 0);
        trig();
        prev = int'(count);
        g = 0;
        while (int'(count) == prev && g < LIMIT) begin @(negedge clk); g++; end
        prev = int'(count);
        g = 0;
        while (int'(count) == prev && g < LIMIT) begin @(negedge clk); g++; end
        check(g == 4, "R6 prescale loaded once hold released", g, 4);
    endtask

    task automatic t_quiet();
        int g;
        setup(0, 3, 0, 2, 1'b0);
        tick_n(3);
        clear_flag();
        trig();
        check(upd_pulse == 1'b1, "R7 quiet trigger still pulses", int'(upd_pulse), 1);
        check(upd_flag == 1'b0, "R7 quiet trigger leaves flag", int'(upd_flag), 0);
        cnt_en = 1'b1;
        wait_pulse(g);
        check(upd_flag == 1'b1, "R7 repetition update sets flag", int'(upd_flag), 1);
        cnt_en = 1'b0;
        tick_n(3);
        clear_flag();
        wr(2'd3, 0);
        trig();
        check(upd_flag == 1'b1, "R7 loud trigger sets flag", int'(upd_flag), 1);
    endtask

    task automatic t_period_write(input bit buffered);
        int g;
        int g2;
        setup(0, 3, 1, buffered ? 4 : 0, 1'b1);
        wait_pulse(g);
        wr(2'd0, 1);
        wait_pulse(g);
        g = g + 1;
        wait_pulse(g2);
        if (buffered) begin
            check(g == 8, "R8 buffered write waits for update", g, 8);
            check(g2 == 4, "R8 new period after update", g2, 4);
        end else begin
            check(g == 6, "R9 direct write used at next reload", g, 6);
            check(g2 == 4, "R9 new period steady", g2, 4);
        end
    endtask

    initial begin
        tick_n(3);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sequence();
        t_prescale_halt();
        t_gap(1, 3, 0);
        t_gap(0, 4, 2);
        t_gap(2, 1, 1);
        t_trigger();
        t_hold();
        t_quiet();
        t_period_write(1'b1);
        t_period_write(1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule